// File: doc/BRIEF.md
# Time-Base Timer with Square-Wave Buzzer Output

This block is a free-running binary prescaler with two jobs. The first is a periodic time-base interrupt at one of eight rates. The second is a square wave with exactly 50% duty on a divider-output pin, meant to drive a piezo buzzer. The prescaler advances on one of two clock-enable strobes, both inside a single system clock domain. One strobe stands for a fast oscillator and the other for a slow one. A control bit chooses which strobe counts.

An 8-bit control register holds the output enable, the output rate, the source select, the interrupt enable and the interrupt rate. A single-cycle write port loads it. The two rate tables are fixed and irregular, and each source has its own table. The interrupt is a one-cycle request taken from the rising edge of the selected prescaler bit. Changing the rate or the source does not raise a false request.

Two parameters, `FC_TRIM` and `FS_TRIM`, reduce every exponent of the fast table or the slow table by a constant. Any result below 1 is raised to 1. Both default to 0, and they exist so that a small configuration can be swept in full.

Top module: `tbt_buzzer_timer`

## Requirements
- R1: After reset the whole control register is 0, `irq_o` and `dvo_o` are low, and neither output becomes active while no write has been made, even with the strobes running.
- R2: Control bit 4 selects the counting strobe: at 0 only `fast_tick_i` advances the prescaler, at 1 only `slow_tick_i`; the other strobe has no effect.
- R3: With bit 4 at 0, interrupt code c in bits 2:0 (0 to 7) gives one request per 2^n advances, n being 23, 21, 16, 14, 13, 12, 11, 9 for c = 0..7, minus `FC_TRIM`, with a floor of 1.
- R4: With bit 4 at 1, code c gives one request per 2^n advances, n being 15, 13, 8, 6, 5, 4, 3, 1 for c = 0..7, minus `FS_TRIM`, with a floor of 1.
- R5: `irq_o` is high for single cycles only, and only while bit 3 (interrupt enable) is 1; starting from a cleared prescaler, W advances (W a multiple of 2^n) give exactly W/2^n requests.
- R6: With bit 7 at 1, output code d in bits 6:5 gives a square wave of period 2^m advances: m is 13 - d (minus `FC_TRIM`, floor 1) for the fast source and 5 - d (minus `FS_TRIM`, floor 1) for the slow source. It is high for exactly half of every period.
- R7: While bit 7 is 0, `dvo_o` is held low.
- R8: A write that changes the source bit or the interrupt code raises no request in the cycle that follows, even when the newly selected prescaler bit is 1 while the old one was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fast_tick_i | input | 1 | Clock-enable strobe of the fast source |
| slow_tick_i | input | 1 | Clock-enable strobe of the slow source |
| wr_en_i | input | 1 | Loads the control register with `wr_data_i` |
| wr_data_i | input | 8 | Control value: [7] output enable, [6:5] output rate, [4] source, [3] interrupt enable, [2:0] interrupt rate |
| irq_o | output | 1 | One-cycle time-base interrupt request |
| dvo_o | output | 1 | Square-wave buzzer output |

## Verification
Two events can land on the same clock edge: a control write that selects a new interrupt tap, and a rising edge on that tap. To provoke this, the bench runs the slow source up to a count of 6 on the fastest code and stops the strobes. It then writes the code whose tap is bit 2. That bit is already 1, while the old tap (bit 0) is 0. The design is correct if `irq_o` stays low on every following cycle. The bench also checks that the interrupt and the buzzer wave, which both come from the same prescaler, each keep their own expected counts over full windows of every code of both tables.

// File: rtl/tbt_pkg.sv
package tbt_pkg;

  typedef struct packed {
    logic       dvo_en;
    logic [1:0] dvo_rate;
    logic       src_slow;
    logic       irq_en;
    logic [2:0] irq_rate;
  } tbt_cfg_t;

  localparam int unsigned CFG_W = $bits(tbt_cfg_t);

  // fast-source interrupt exponents
  function automatic int unsigned fast_irq_exp(input logic [2:0] code);
    case (code)
      3'd0:    return 23;
      3'd1:    return 21;
      3'd2:    return 16;
      3'd3:    return 14;
      3'd4:    return 13;
      3'd5:    return 12;
      3'd6:    return 11;
      default: return 9;
    endcase
  endfunction

  // slow-source interrupt exponents
  function automatic int unsigned slow_irq_exp(input logic [2:0] code);
    case (code)
      3'd0:    return 15;
      3'd1:    return 13;
      3'd2:    return 8;
      3'd3:    return 6;
      3'd4:    return 5;
      3'd5:    return 4;
      3'd6:    return 3;
      default: return 1;
    endcase
  endfunction

  function automatic int unsigned fast_dvo_exp(input logic [1:0] code);
    return 13 - int'(code);
  endfunction

  function automatic int unsigned slow_dvo_exp(input logic [1:0] code);
    return 5 - int'(code);
  endfunction

  // apply trim with floor of 1 and ceiling of the counter width
  function automatic int unsigned trim_exp(input int unsigned e,
                                           input int unsigned trim,
                                           input int unsigned max_e);
    int unsigned r;
    r = (e <= trim) ? 1 : e - trim;
    if (r > max_e) r = max_e;
    return r;
  endfunction

endpackage

// File: rtl/tbt_rst_sync.sv
module tbt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/tbt_prescaler.sv
module tbt_prescaler #(
  parameter int unsigned CNT_W = 23
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_slow_i,
  input  logic             fast_tick_i,
  input  logic             slow_tick_i,
  output logic             adv_o,
  output logic [CNT_W-1:0] ctr_o
);
  logic [CNT_W-1:0] ctr_q;
  logic [CNT_W-1:0] ctr_d;
  logic             adv;

  always_comb begin
    adv   = src_slow_i ? slow_tick_i : fast_tick_i;
    ctr_d = ctr_q;
    if (adv) ctr_d = ctr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctr_q <= '0;
    else         ctr_q <= ctr_d;
  end

  assign adv_o = adv;
  assign ctr_o = ctr_q;
endmodule

// File: rtl/tbt_tap_sel.sv
module tbt_tap_sel
  import tbt_pkg::*;
#(
  parameter int unsigned CNT_W   = 23,
  parameter int unsigned FC_TRIM = 0,
  parameter int unsigned FS_TRIM = 0
) (
  input  tbt_cfg_t         cfg_i,
  input  logic [CNT_W-1:0] ctr_i,
  output logic             irq_tap_o,
  output logic             dvo_tap_o
);
  localparam int unsigned N_IRQ = 8;
  localparam int unsigned N_DVO = 4;

  logic [N_IRQ-1:0] irq_fast_v;
  logic [N_IRQ-1:0] irq_slow_v;
  logic [N_DVO-1:0] dvo_fast_v;
  logic [N_DVO-1:0] dvo_slow_v;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_irq
    localparam int unsigned EF = trim_exp(fast_irq_exp(3'(g)), FC_TRIM, CNT_W);
    localparam int unsigned ES = trim_exp(slow_irq_exp(3'(g)), FS_TRIM, CNT_W);
    assign irq_fast_v[g] = ctr_i[EF-1];
    assign irq_slow_v[g] = ctr_i[ES-1];
  end

  for (genvar g = 0; g < N_DVO; g++) begin : g_dvo
    localparam int unsigned EF = trim_exp(fast_dvo_exp(2'(g)), FC_TRIM, CNT_W);
    localparam int unsigned ES = trim_exp(slow_dvo_exp(2'(g)), FS_TRIM, CNT_W);
    assign dvo_fast_v[g] = ctr_i[EF-1];
    assign dvo_slow_v[g] = ctr_i[ES-1];
  end

  always_comb begin
    if (cfg_i.src_slow) begin
      irq_tap_o = irq_slow_v[cfg_i.irq_rate];
      dvo_tap_o = dvo_slow_v[cfg_i.dvo_rate];
    end else begin
      irq_tap_o = irq_fast_v[cfg_i.irq_rate];
      dvo_tap_o = dvo_fast_v[cfg_i.dvo_rate];
    end
  end
endmodule

// File: rtl/tbt_irq_edge.sv
module tbt_irq_edge #(
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tap_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             en_i,
  output logic             irq_o
);
  logic             tap_q;
  logic [SEL_W-1:0] sel_q;
  logic             irq_q;
  logic             irq_d;

  // a rise only counts when the tap selection was unchanged since last cycle
  always_comb begin
    irq_d = tap_i & ~tap_q & en_i & (sel_i == sel_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tap_q <= 1'b0;
      sel_q <= '0;
      irq_q <= 1'b0;
    end else begin
      tap_q <= tap_i;
      sel_q <= sel_i;
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/tbt_buzzer_timer.sv
module tbt_buzzer_timer
  import tbt_pkg::*;
#(
  parameter int unsigned CNT_W   = 23,
  parameter int unsigned FC_TRIM = 0,
  parameter int unsigned FS_TRIM = 0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fast_tick_i,
  input  logic       slow_tick_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic       irq_o,
  output logic       dvo_o
);
  localparam int unsigned SEL_W = 4;

  logic             rst_n_sync;
  tbt_cfg_t         cfg_q;
  tbt_cfg_t         cfg_d;
  logic             adv;
  logic [CNT_W-1:0] ctr;
  logic             irq_tap;
  logic             dvo_tap;
  logic             dvo_q;
  logic             dvo_d;

  tbt_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en_i) cfg_d = tbt_cfg_t'(wr_data_i);
  end

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) cfg_q <= '0;
    else             cfg_q <= cfg_d;
  end

  tbt_prescaler #(.CNT_W(CNT_W)) u_prescaler (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_sync),
    .src_slow_i  (cfg_q.src_slow),
    .fast_tick_i (fast_tick_i),
    .slow_tick_i (slow_tick_i),
    .adv_o       (adv),
    .ctr_o       (ctr)
  );

  tbt_tap_sel #(
    .CNT_W   (CNT_W),
    .FC_TRIM (FC_TRIM),
    .FS_TRIM (FS_TRIM)
  ) u_tap_sel (
    .cfg_i     (cfg_q),
    .ctr_i     (ctr),
    .irq_tap_o (irq_tap),
    .dvo_tap_o (dvo_tap)
  );

  tbt_irq_edge #(.SEL_W(SEL_W)) u_irq_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .tap_i  (irq_tap),
    .sel_i  ({cfg_q.src_slow, cfg_q.irq_rate}),
    .en_i   (cfg_q.irq_en),
    .irq_o  (irq_o)
  );

  always_comb begin
    dvo_d = cfg_q.dvo_en & dvo_tap;
  end

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) dvo_q <= 1'b0;
    else             dvo_q <= dvo_d;
  end

  assign dvo_o = dvo_q;
endmodule

// File: rtl/tbt_buzzer_timer_chk.sv
module tbt_buzzer_timer_chk
  import tbt_pkg::*;
#(
  parameter int unsigned CNT_W = 23
) (
  input logic             clk_i,
  input logic             rst_n,
  input tbt_cfg_t         cfg_q,
  input logic             adv,
  input logic [CNT_W-1:0] ctr,
  input logic             wr_en_i,
  input logic [7:0]       wr_data_i,
  input logic             irq_o,
  input logic             dvo_o
);
  tbt_cfg_t wr_cfg;
  assign wr_cfg = tbt_cfg_t'(wr_data_i);

  // R5
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |=> !irq_o);

  // R5
  irq_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> $past(cfg_q.irq_en));

  // R7
  dvo_off_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !cfg_q.dvo_en |=> !dvo_o);

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !adv |=> $stable(ctr));

  // R8
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && ({wr_cfg.src_slow, wr_cfg.irq_rate} != {cfg_q.src_slow, cfg_q.irq_rate}))
      |=> ##1 !irq_o);
endmodule

bind tbt_buzzer_timer tbt_buzzer_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_n_sync),
  .cfg_q     (cfg_q),
  .adv       (adv),
  .ctr       (ctr),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .irq_o     (irq_o),
  .dvo_o     (dvo_o)
);

// File: tb/tbt_buzzer_timer_tb.sv
module tbt_buzzer_timer_tb;
  localparam int FC_TRIM = 9;
  localparam int FS_TRIM = 0;
  localparam int CNT_W   = 23;

  logic       clk;
  logic       rst_n;
  logic       fast_tick;
  logic       slow_tick;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       irq;
  logic       dvo;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  int n_irq, n_dhi, n_drise;

  tbt_buzzer_timer #(.CNT_W(CNT_W), .FC_TRIM(FC_TRIM), .FS_TRIM(FS_TRIM)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .fast_tick_i (fast_tick),
    .slow_tick_i (slow_tick),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .irq_o       (irq),
    .dvo_o       (dvo)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int trimmed(int e, int t);
    return (e <= t) ? 1 : e - t;
  endfunction

  function automatic int irq_n(int src, int c);
    int f[8] = '{23, 21, 16, 14, 13, 12, 11, 9};
    int s[8] = '{15, 13, 8, 6, 5, 4, 3, 1};
    return src ? trimmed(s[c], FS_TRIM) : trimmed(f[c], FC_TRIM);
  endfunction

  function automatic int dvo_n(int src, int d);
    return src ? trimmed(5 - d, FS_TRIM) : trimmed(13 - d, FC_TRIM);
  endfunction

  function automatic logic [7:0] enc(int den, int drate, int src, int ien, int code);
    return {den[0], drate[1:0], src[0], ien[0], code[2:0]};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; fast_tick = 1'b0; slow_tick = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // drive strobes for w+1 edges, sample after each one
  task automatic run_count(int w, logic f, logic s);
    logic prev;
    prev = dvo;
    n_irq = 0; n_dhi = 0; n_drise = 0;
    fast_tick = f; slow_tick = s;
    for (int i = 0; i <= w; i++) begin
      @(negedge clk);
      if (irq) n_irq++;
      if (dvo) n_dhi++;
      if (dvo && !prev) n_drise++;
      prev = dvo;
    end
    fast_tick = 1'b0; slow_tick = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; fast_tick = 1'b0; slow_tick = 1'b0; wr_en = 1'b0; wr_data = '0;
    do_reset();

    // R1: reset state, nothing active without a write
    chk("R1 irq after reset", int'(irq), 0);
    chk("R1 dvo after reset", int'(dvo), 0);
    run_count(64, 1'b1, 1'b1);
    chk("R1 irq count without write", n_irq, 0);
    chk("R1 dvo high without write", n_dhi, 0);

    // R3 / R4 / R5 / R7: every interrupt code, both sources, buzzer off
    for (int src = 0; src < 2; src++) begin
      for (int c = 0; c < 8; c++) begin
        int n, w;
        n = irq_n(src, c);
        w = (1 << n) > 2048 ? (1 << n) : 2048;
        do_reset();
        wr(enc(0, 3, src, 1, c));
        run_count(w, src == 0, src == 1);
        chk(src ? "R4 irq count" : "R3 irq count", n_irq, w >> n);
        chk("R7 dvo low when disabled", n_dhi, 0);
      end
    end

    // R2: the unselected strobe has no effect
    do_reset();
    wr(enc(1, 3, 0, 1, 7));
    run_count(2048, 1'b0, 1'b1);
    chk("R2 fast source ignores slow strobe irq", n_irq, 0);
    chk("R2 fast source ignores slow strobe dvo", n_dhi, 0);
    do_reset();
    wr(enc(1, 3, 1, 1, 7));
    run_count(2048, 1'b1, 1'b0);
    chk("R2 slow source ignores fast strobe irq", n_irq, 0);

    // R6 / R5: buzzer rates, duty, interrupt disabled
    for (int src = 0; src < 2; src++) begin
      for (int d = 0; d < 4; d++) begin
        int m;
        m = dvo_n(src, d);
        do_reset();
        wr(enc(1, d, src, 0, 7));
        run_count(2048, src == 0, src == 1);
        chk("R6 dvo high cycles", n_dhi, 1024);
        chk("R6 dvo rising edges", n_drise, 2048 >> m);
        chk("R5 irq disabled", n_irq, 0);
      end
    end

    // R8: rate write while new tap is already high, old tap low
    do_reset();
    wr(enc(0, 0, 1, 1, 7));
    run_count(5, 1'b0, 1'b1);
    chk("R8 pulses before rewrite", n_irq, 3);
    wr(enc(0, 0, 1, 1, 6));
    for (int i = 0; i < 4; i++) begin
      chk("R8 no spurious irq", int'(irq), 0);
      @(negedge clk);
    end

    finish_run();
  end
endmodule